// File: doc/BRIEF.md
# Branch Sequencer with Interrupt Polling

This block is a cycle-exact micro-sequencer for a small slice of an 8-bit processor. On every clock it performs exactly one access on a byte-wide memory bus. It fetches opcodes and runs two relative conditional branches, both of which test an external zero-flag input. Every other opcode behaves as a one-byte no-op that takes two cycles. A taken branch adds its signed offset to the low byte of the program counter first. If the high byte must change, it is corrected in an extra cycle, and during that cycle the bus shows the half-updated address.

The core of the block is the decision of when a pending level interrupt replaces the next opcode fetch. The interrupt line is sampled at the end of every real opcode-fetch cycle. A branch that crosses a page samples it a second time at the end of its third cycle. A taken branch that stays on its page does not sample it again, so a request that first shows up during its second or third cycle waits until one more instruction has run. When a fetch is diverted, a forced break sequence runs. It pushes the return address and a status byte to the stack page, loads the handler address from the top two bytes of memory, and masks further requests.

The memory returns read data in the same cycle as the address. A `sync` strobe marks the cycles in which a real opcode is fetched.

Top module: `bseq_core`

## Requirements
- R1: While `rst_n` is low, and until the second rising clock edge after it is released, `sync` and `wr_en` are 0 and `addr` equals the RESET_PC parameter. The first cycle after that is an opcode fetch at RESET_PC.
- R2: `sync` is 1 exactly in cycles that fetch a real opcode at the program counter. It is 0 on a diverted fetch and in all other cycles.
- R3: Any opcode other than 0xF0 and 0xD0 takes two cycles. The second cycle reads the next address without advancing past it, so the following fetch is at opcode address + 1.
- R4: Opcode 0xF0 branches when `zero_flag` is 1 and opcode 0xD0 branches when it is 0. The offset byte follows the opcode. An untaken branch takes two cycles, and the next fetch is at opcode address + 2.
- R5: A taken branch whose target (opcode address + 2 + signed offset) has the same high byte as opcode address + 2 takes three cycles. The third cycle reads opcode address + 2, and the next fetch is at the target.
- R6: A taken branch that crosses a page takes four cycles. The fourth cycle reads {old high byte, target low byte}, and the next fetch is at the target.
- R7: `irq` is sampled at the end of each real opcode-fetch cycle. If it was 1 there and the mask is clear, the fetch that follows the instruction is diverted. A request present only during the offset cycle of an untaken branch, or the dummy cycle of a no-op, is not seen until the next fetch.
- R8: A page-crossing taken branch also samples `irq` at the end of its third cycle, and a request seen there diverts the fetch right after the fourth cycle. A request that appears only in the fourth cycle is not seen there.
- R9: A taken same-page branch does not sample `irq` in its second or third cycle. A branch-to-self (offset 0xFE) that first sees the request in those cycles runs one more iteration before the handler is entered.
- R10: The forced sequence lasts 7 cycles. Cycles 1 and 2 read the program counter without advancing it. Cycles 3 to 5 write the return high byte, the return low byte, and the status byte to 0x0100+SP, with SP decrementing after each write. The status byte has bit 5 = 1, bit 4 (break) = 0, bit 2 = mask, bit 1 = `zero_flag`, and all other bits 0. Cycles 6 and 7 read 0xFFFE (new low byte) and 0xFFFF (new high byte). The handler fetch follows.
- R11: Entering the handler sets the mask, and while the mask is set `irq` has no effect. Reset clears the mask and sets SP to 0xFF.
- R12: `wr_en` is 1 only in the three push cycles, and every write goes to page 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq | input | 1 | Level interrupt request, active high |
| zero_flag | input | 1 | Branch condition and status bit 1 |
| rd_data | input | 8 | Read data for the current address |
| addr | output | 16 | Bus address of the current cycle |
| wr_en | output | 1 | Write strobe |
| wr_data | output | 8 | Write data |
| sync | output | 1 | High on real opcode-fetch cycles |

## Verification
Some properties are checked on every cycle. Writes must fall only in page 0x01, come in runs of exactly three with a falling address, and be followed by reads of 0xFFFE, then 0xFFFF, then a real fetch. No write may occur once the mask is set. `sync` and `wr_en` must never be high together, and the gap between real fetches must stay bounded. The polling points themselves are not visible to such local checks. Only the scenarios can show them: an interrupt raised in each individual cycle of untaken, same-page, page-crossing and branch-to-self branches, with the handler entry cycle and the pushed return address compared against values worked out by hand and against a queue-based model on every clock.

// File: rtl/bseq_pkg.sv
`timescale 1ns/1ps
package bseq_pkg;

  // Sequencer states; ST_FETCH doubles as the diverted fetch when an interrupt is pending.
  typedef enum logic [3:0] {
    ST_FETCH,
    ST_OPER,
    ST_BR_TAKE,
    ST_BR_FIX,
    ST_I_DUMMY,
    ST_I_PCH,
    ST_I_PCL,
    ST_I_STAT,
    ST_I_VECL,
    ST_I_VECH
  } seq_state_e;

  localparam logic [7:0] OPC_BR_ZSET = 8'hF0;  // R4: branch when zero flag is 1
  localparam logic [7:0] OPC_BR_ZCLR = 8'hD0;  // R4: branch when zero flag is 0
  localparam logic [7:0] STACK_PAGE  = 8'h01;  // R12

  function automatic logic is_branch(input logic [7:0] op);
    return (op == OPC_BR_ZSET) || (op == OPC_BR_ZCLR);
  endfunction

  function automatic logic branch_taken(input logic [7:0] op, input logic z);
    return (op == OPC_BR_ZSET) ? z : !z;
  endfunction

  // R10: bit5 set, break bit clear, mask in bit2, zero in bit1
  function automatic logic [7:0] status_byte(input logic mask, input logic z);
    return {2'b00, 1'b1, 1'b0, 1'b0, mask, z, 1'b0};
  endfunction

endpackage

// File: rtl/bseq_pc.sv
`timescale 1ns/1ps
module bseq_pc #(
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = 16'h0200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_en,
  input  logic              add_en,
  input  logic              fix_en,
  input  logic              vlo_en,
  input  logic              vhi_en,
  input  logic [7:0]        off,
  input  logic [7:0]        din,
  output logic [ADDR_W-1:0] pc,
  output logic              wrap
);
  localparam int HI_W = ADDR_W - 8;

  logic [ADDR_W-1:0] pc_q, pc_d;
  logic              dn_q, dn_d;
  logic [8:0]        lo_sum;
  logic              pc_en;

  // Low-byte add; a carry for a forward offset or no carry for a backward
  // offset means the high byte is wrong and needs a fixup cycle (R6).
  assign lo_sum = {1'b0, pc_q[7:0]} + {1'b0, off};
  assign wrap   = off[7] ^ lo_sum[8];
  assign pc_en  = inc_en | add_en | fix_en | vlo_en | vhi_en;

  always_comb begin
    pc_d = pc_q;
    dn_d = dn_q;
    if (inc_en) pc_d = pc_q + ADDR_W'(1);
    if (add_en) begin
      pc_d[7:0] = lo_sum[7:0];
      dn_d      = off[7];
    end
    if (fix_en) begin
      pc_d[ADDR_W-1:8] = dn_q ? (pc_q[ADDR_W-1:8] - HI_W'(1))
                              : (pc_q[ADDR_W-1:8] + HI_W'(1));
    end
    if (vlo_en) pc_d[7:0]        = din;
    if (vhi_en) pc_d[ADDR_W-1:8] = HI_W'(din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= RESET_PC;
      dn_q <= 1'b0;
    end else if (pc_en) begin
      pc_q <= pc_d;
      dn_q <= dn_d;
    end
  end

  assign pc = pc_q;
endmodule

// File: rtl/bseq_stack.sv
`timescale 1ns/1ps
module bseq_stack #(
  parameter int             SP_W     = 8,
  parameter logic [SP_W-1:0] SP_RESET = 8'hFF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_en,
  output logic [SP_W-1:0] sp
);
  logic [SP_W-1:0] sp_q, sp_d;

  // R10: post-decrement after every push
  always_comb sp_d = sp_q - SP_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sp_q <= SP_RESET;
    else if (push_en) sp_q <= sp_d;
  end

  assign sp = sp_q;
endmodule

// File: rtl/bseq_irq_poll.sv
`timescale 1ns/1ps
module bseq_irq_poll (
  input  logic clk,
  input  logic rst_n,
  input  logic irq,
  input  logic poll_set,   // fresh sample (end of a real opcode fetch)
  input  logic poll_or,    // extra sample merged in (before a page fixup)
  input  logic take_clr,   // fetch has been diverted
  input  logic mask_set,   // handler entered
  output logic take,
  output logic mask
);
  logic take_q, take_d, take_en;
  logic mask_q;
  logic req;

  assign req     = irq & ~mask_q;               // R11
  assign take_en = poll_set | poll_or | take_clr;

  always_comb begin
    take_d = take_q;
    if (take_clr)      take_d = 1'b0;
    else if (poll_set) take_d = req;              // R7
    else if (poll_or)  take_d = take_q | req;     // R8
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       take_q <= 1'b0;
    else if (take_en) take_q <= take_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mask_q <= 1'b0;
    else if (mask_set) mask_q <= 1'b1;
  end

  assign take = take_q;
  assign mask = mask_q;
endmodule

// File: rtl/bseq_core.sv
`timescale 1ns/1ps
module bseq_core
  import bseq_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = 16'h0200,
  parameter logic [7:0]      SP_RESET = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq,
  input  logic              zero_flag,
  input  logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] addr,
  output logic              wr_en,
  output logic [7:0]        wr_data,
  output logic              sync
);
  localparam logic [ADDR_W-1:0] VEC_LO = {{(ADDR_W-1){1'b1}}, 1'b0};
  localparam logic [ADDR_W-1:0] VEC_HI = {ADDR_W{1'b1}};

  // Reset: asserted asynchronously, released after two clock edges (R1)
  logic rs_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rs_meta    <= 1'b1;
      rst_sync_n <= rs_meta;
    end
  end

  seq_state_e        state_q, state_d;
  logic [7:0]        op_q, op_d, off_q, off_d;
  logic              op_en, off_en;
  logic [ADDR_W-1:0] pc;
  logic              wrap;
  logic [7:0]        sp;
  logic              take, i_flag;

  logic inc_en, add_en, fix_en, vlo_en, vhi_en, push_en;
  logic poll_set, poll_or, take_clr, mask_set;
  logic sync_c, wr_c;
  logic [ADDR_W-1:0] addr_c;
  logic [7:0]        wdata_c;

  bseq_pc #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_pc (
    .clk(clk), .rst_n(rst_sync_n),
    .inc_en(inc_en), .add_en(add_en), .fix_en(fix_en),
    .vlo_en(vlo_en), .vhi_en(vhi_en),
    .off(off_q), .din(rd_data), .pc(pc), .wrap(wrap)
  );

  bseq_stack #(.SP_W(8), .SP_RESET(SP_RESET)) u_stack (
    .clk(clk), .rst_n(rst_sync_n), .push_en(push_en), .sp(sp)
  );

  bseq_irq_poll u_poll (
    .clk(clk), .rst_n(rst_sync_n), .irq(irq),
    .poll_set(poll_set), .poll_or(poll_or), .take_clr(take_clr),
    .mask_set(mask_set), .take(take), .mask(i_flag)
  );

  // Next-state and bus decode
  always_comb begin
    state_d  = state_q;
    op_d     = op_q;
    off_d    = off_q;
    op_en    = 1'b0;
    off_en   = 1'b0;
    inc_en   = 1'b0;
    add_en   = 1'b0;
    fix_en   = 1'b0;
    vlo_en   = 1'b0;
    vhi_en   = 1'b0;
    push_en  = 1'b0;
    poll_set = 1'b0;
    poll_or  = 1'b0;
    take_clr = 1'b0;
    mask_set = 1'b0;
    sync_c   = 1'b0;
    wr_c     = 1'b0;
    wdata_c  = 8'h00;
    addr_c   = pc;
    unique case (state_q)
      ST_FETCH: begin
        if (take) begin
          // R10: diverted fetch, program counter held as return address
          take_clr = 1'b1;
          state_d  = ST_I_DUMMY;
        end else begin
          sync_c   = 1'b1;          // R2
          op_d     = rd_data;
          op_en    = 1'b1;
          inc_en   = 1'b1;
          poll_set = 1'b1;          // R7
          state_d  = ST_OPER;
        end
      end
      ST_OPER: begin
        if (is_branch(op_q)) begin
          off_d   = rd_data;
          off_en  = 1'b1;
          inc_en  = 1'b1;
          state_d = branch_taken(op_q, zero_flag) ? ST_BR_TAKE : ST_FETCH;  // R4
        end else begin
          state_d = ST_FETCH;       // R3: dummy read, no increment
        end
      end
      ST_BR_TAKE: begin
        add_en  = 1'b1;             // R5
        poll_or = wrap;             // R8 sampled only when a fixup follows; R9 otherwise
        state_d = wrap ? ST_BR_FIX : ST_FETCH;
      end
      ST_BR_FIX: begin
        fix_en  = 1'b1;             // R6
        state_d = ST_FETCH;
      end
      ST_I_DUMMY: state_d = ST_I_PCH;
      ST_I_PCH: begin
        addr_c  = ADDR_W'({STACK_PAGE, sp});
        wr_c    = 1'b1;
        wdata_c = pc[15:8];
        push_en = 1'b1;
        state_d = ST_I_PCL;
      end
      ST_I_PCL: begin
        addr_c  = ADDR_W'({STACK_PAGE, sp});
        wr_c    = 1'b1;
        wdata_c = pc[7:0];
        push_en = 1'b1;
        state_d = ST_I_STAT;
      end
      ST_I_STAT: begin
        addr_c  = ADDR_W'({STACK_PAGE, sp});
        wr_c    = 1'b1;
        wdata_c = status_byte(i_flag, zero_flag);
        push_en = 1'b1;
        state_d = ST_I_VECL;
      end
      ST_I_VECL: begin
        addr_c  = VEC_LO;
        vlo_en  = 1'b1;
        state_d = ST_I_VECH;
      end
      ST_I_VECH: begin
        addr_c   = VEC_HI;
        vhi_en   = 1'b1;
        mask_set = 1'b1;            // R11
        state_d  = ST_FETCH;
      end
      default: state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= ST_FETCH;
    else             state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  op_q <= 8'h00;
    else if (op_en)   op_q <= op_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  off_q <= 8'h00;
    else if (off_en)  off_q <= off_d;
  end

  // R1: strobes held low until the internal reset has been released
  assign addr    = addr_c;
  assign wr_en   = wr_c & rst_sync_n;
  assign wr_data = wdata_c;
  assign sync    = sync_c & rst_sync_n;
endmodule

// File: rtl/bseq_checker.sv
`timescale 1ns/1ps
module bseq_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              sync,
  input logic              i_flag
);
  localparam logic [ADDR_W-1:0] VEC_LO = {{(ADDR_W-1){1'b1}}, 1'b0};
  localparam logic [ADDR_W-1:0] VEC_HI = {ADDR_W{1'b1}};

  logic [3:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              gap_q <= 4'd0;
    else if (sync)           gap_q <= 4'd0;
    else if (gap_q != 4'hF)  gap_q <= gap_q + 4'd1;
  end

  p_wr_page_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (addr[15:8] == 8'h01));

  p_sync_no_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sync |-> !wr_en);

  p_push_three_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_en) |=> wr_en ##1 wr_en ##1 !wr_en);

  p_push_dec_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (addr == $past(addr) - ADDR_W'(1)));

  p_vector_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_en) |-> (addr == VEC_LO) ##1 (addr == VEC_HI) ##1 sync);

  p_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    i_flag |-> !wr_en);

  p_fetch_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q <= 4'd10);
endmodule

bind bseq_core bseq_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .addr(addr), .wr_en(wr_en),
  .sync(sync), .i_flag(i_flag)
);

// File: tb/test_bseq_core.sv
`timescale 1ns/1ps
module test_bseq_core;
  localparam logic [15:0] RST_PC  = 16'h0200;
  localparam logic [15:0] HANDLER = 16'h0400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq = 1'b0;
  logic        z = 1'b0;
  logic [7:0]  rd_data = 8'hEA;
  logic [15:0] addr;
  logic        wr_en, sync;
  logic [7:0]  wr_data;

  always #2.5 clk = ~clk;

  bseq_core i_bseq_core (
    .clk(clk), .rst_n(rst_n), .irq(irq), .zero_flag(z), .rd_data(rd_data),
    .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .sync(sync)
  );

  // Sparse byte memory; unset bytes read as a no-op opcode
  logic [7:0] mem [logic [15:0]];
  function automatic logic [7:0] rdm(input logic [15:0] a);
    if (mem.exists(a)) return mem[a];
    return 8'hEA;
  endfunction

  int vectors = 0, miscomp = 0;
  int cyc = 0, rcnt = 0, irq_on = -1, entry = -1;
  logic [7:0] wlog[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscomp++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference model: each instruction expands into a queue of expected bus cycles
  typedef struct packed {
    logic [15:0] a;
    logic        s;
    logic        w;
    logic [7:0]  d;
    logic [1:0]  poll;  // 1: fresh sample, 2: merge sample
    logic [3:0]  req;
  } bcyc_t;

  bcyc_t       q[$];
  logic [15:0] m_pc;
  logic [7:0]  m_sp;
  bit          m_i, m_pend;

  task automatic add(input logic [15:0] a, input logic s, input logic w,
                     input logic [7:0] d, input logic [1:0] p, input int r);
    bcyc_t e;
    e.a = a; e.s = s; e.w = w; e.d = d; e.poll = p; e.req = 4'(r);
    q.push_back(e);
  endtask

  task automatic build();
    logic [15:0] pc, np, tgt;
    logic [7:0]  op, off;
    pc = m_pc;
    if (m_pend) begin
      // R10 forced sequence
      add(pc, 0, 0, 8'h00, 0, 10);
      add(pc, 0, 0, 8'h00, 0, 10);
      add({8'h01, m_sp},        0, 1, pc[15:8], 0, 10);
      add({8'h01, m_sp - 8'd1}, 0, 1, pc[7:0],  0, 10);
      add({8'h01, m_sp - 8'd2}, 0, 1, 8'h20 | {6'd0, z, 1'b0}, 0, 10);
      add(16'hFFFE, 0, 0, 8'h00, 0, 10);
      add(16'hFFFF, 0, 0, 8'h00, 0, 10);
      m_sp   = m_sp - 8'd3;
      m_pc   = {rdm(16'hFFFF), rdm(16'hFFFE)};
      m_i    = 1;   // R11
      m_pend = 0;
    end else begin
      op = rdm(pc);
      add(pc, 1, 0, 8'h00, 1, 2);                       // R2, R7 sample
      if (op == 8'hF0 || op == 8'hD0) begin
        off = rdm(pc + 16'd1);
        add(pc + 16'd1, 0, 0, 8'h00, 0, 4);             // R4
        np = pc + 16'd2;
        if ((op == 8'hF0) != z) m_pc = np;
        else begin
          tgt = np + {{8{off[7]}}, off};
          if (tgt[15:8] != np[15:8]) begin
            add(np, 0, 0, 8'h00, 2, 8);                 // R8 extra sample
            add({np[15:8], tgt[7:0]}, 0, 0, 8'h00, 0, 6); // R6
          end else begin
            add(np, 0, 0, 8'h00, 0, 5);                 // R5, R9 no sample
          end
          m_pc = tgt;
        end
      end else begin
        add(pc + 16'd1, 0, 0, 8'h00, 0, 3);             // R3
        m_pc = pc + 16'd1;
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      rcnt = 0; cyc = 0;
      m_pc = RST_PC; m_sp = 8'hFF; m_i = 0; m_pend = 0;
      q.delete();
    end else if (rcnt < 2) begin
      rcnt++;
    end else if (q.size() != 0) begin
      bcyc_t e;
      e = q.pop_front();
      if (e.poll == 2'd1) m_pend = irq && !m_i;
      else if (e.poll == 2'd2) m_pend = m_pend || (irq && !m_i);
      cyc++;
    end
  end

  always @(negedge clk) begin
    irq = rst_n && (irq_on >= 0) && (cyc >= irq_on);
    if (rst_n && rcnt == 2) begin
      bcyc_t e;
      if (q.size() == 0) build();
      e = q[0];
      vectors++;
      if (addr !== e.a || sync !== e.s || wr_en !== e.w || (e.w && wr_data !== e.d)) begin
        miscomp++;
        $display("FAIL R%0d cycle %0d actual=%h/%b/%b/%h expected=%h/%b/%b/%h",
                 e.req, cyc, addr, sync, wr_en, wr_data, e.a, e.s, e.w, e.d);
      end
      if (sync && addr == HANDLER && entry < 0) entry = cyc;
      if (wr_en) begin
        wlog.push_back(wr_data);
        chk(addr[15:8] == 8'h01, "R12 write page", int'(addr[15:8]), 1);
      end
    end else begin
      // R1: quiet bus while reset is held or being released
      chk(sync === 1'b0 && wr_en === 1'b0 && addr === RST_PC, "R1 reset bus",
          int'({sync, wr_en, addr}), int'(RST_PC));
    end
    rd_data = rdm(addr);
  end

  task automatic begin_case();
    @(posedge clk); #1;
    rst_n = 0; irq_on = -1; entry = -1;
    wlog.delete();
    mem.delete();
    mem[16'hFFFE] = HANDLER[7:0];
    mem[16'hFFFF] = HANDLER[15:8];
  endtask

  task automatic run_case(input int on, input bit zz, input int ncyc);
    z = zz; irq_on = on;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    while (cyc < ncyc) @(posedge clk);
    #1;
  endtask

  task automatic chk_push(input string tag, input logic [7:0] h, input logic [7:0] l,
                          input logic [7:0] s);
    chk(wlog.size() == 3, {tag, " push count"}, wlog.size(), 3);
    if (wlog.size() == 3) begin
      chk(wlog[0] == h, {tag, " pushed high"}, wlog[0], h);
      chk(wlog[1] == l, {tag, " pushed low"},  wlog[1], l);
      chk(wlog[2] == s, {tag, " status"},      wlog[2], s);
    end
  endtask

  initial begin
    // S1: straight line, same-page and page-crossing branches, no request (R3 R4 R5 R6)
    begin_case();
    mem[16'h0201] = 8'hD0; mem[16'h0202] = 8'h7F;
    mem[16'h0282] = 8'hF0; mem[16'h0283] = 8'h05;
    mem[16'h0284] = 8'hD0; mem[16'h0285] = 8'h7E;
    run_case(-1, 0, 60);
    chk(entry == -1, "R7 no request no entry", entry, -1);

    // S2: request during a no-op fetch; stays high after entry (R7 R10 R11)
    begin_case();
    run_case(0, 0, 40);
    chk(entry == 9, "R7 entry after no-op", entry, 9);
    chk_push("R10 no-op", 8'h02, 8'h01, 8'h20);
    chk(wlog.size() == 3, "R11 masked while held", wlog.size(), 3);

    // S3: request at the fetch of an untaken branch (R4 R7)
    begin_case();
    mem[16'h0200] = 8'hF0; mem[16'h0201] = 8'h05;
    run_case(0, 0, 20);
    chk(entry == 9, "R4 entry after untaken branch", entry, 9);
    chk_push("R10 untaken", 8'h02, 8'h02, 8'h20);

    // S4: request first seen in the offset cycle (R7)
    begin_case();
    mem[16'h0200] = 8'hF0; mem[16'h0201] = 8'h05;
    run_case(1, 0, 20);
    chk(entry == 11, "R7 missed in offset cycle", entry, 11);

    // S5: branch-to-self loop (R9 R10)
    begin_case();
    mem[16'h0200] = 8'hF0; mem[16'h0201] = 8'hFE;
    run_case(0, 1, 20);
    chk(entry == 10, "R9 loop request at fetch", entry, 10);
    chk_push("R10 loop", 8'h02, 8'h00, 8'h22);

    begin_case();
    mem[16'h0200] = 8'hF0; mem[16'h0201] = 8'hFE;
    run_case(1, 1, 20);
    chk(entry == 13, "R9 loop request in cycle 2", entry, 13);

    begin_case();
    mem[16'h0200] = 8'hF0; mem[16'h0201] = 8'hFE;
    run_case(2, 1, 20);
    chk(entry == 13, "R9 loop request in cycle 3", entry, 13);

    // S6: backward page-crossing branch (R6 R8)
    begin_case();
    mem[16'h0200] = 8'hD0; mem[16'h0201] = 8'hF0;
    run_case(2, 0, 20);
    chk(entry == 11, "R8 request before fixup", entry, 11);
    chk_push("R6 crossing return", 8'h01, 8'hF2, 8'h20);

    begin_case();
    mem[16'h0200] = 8'hD0; mem[16'h0201] = 8'hF0;
    run_case(3, 0, 20);
    chk(entry == 13, "R8 request in fixup cycle", entry, 13);

    // S7: same-page forward branch, request in cycle 3 (R5 R9)
    begin_case();
    mem[16'h0200] = 8'hD0; mem[16'h0201] = 8'h04;
    run_case(2, 0, 20);
    chk(entry == 12, "R9 same-page cycle 3 request", entry, 12);
    chk_push("R5 same-page return", 8'h02, 8'h07, 8'h20);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    miscomp++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end
endmodule